// File: doc/BRIEF.md
# SPN Round Linear Diffusion Layer

This block computes the linear half of one round of a 128-bit substitution-permutation cipher. The state is treated as four 32-bit words. Word i holds the four bytes of row i, and byte j of a word (bits 8j+7 down to 8j) sits in column j. Each column is mixed on its own by an AND-mask bit permutation. The rows and columns are then swapped, and the result is XORed with a 128-bit round key.

The odd/even round select picks one of two rotations of the mask sequence, so a round engine that alternates round types can share one instance. With an all-zero key the block applies only the permutation and the transposition. A key scheduler can therefore pass encryption round keys through it to obtain decryption round keys. The byte substitution stage, the key schedule and round counting live outside this block.

The parameter `REG_OUT` selects the output timing. When it is 1, the default, the result is registered with one cycle of latency. When it is 0, the path is purely combinational.

Top module: `spn_lin_layer`

## Requirements
- R1: With masks m0=0xfc, m1=0xf3, m2=0xcf, m3=0x3f and `odd_round`=1, the mask sequence is M[0..3] = m3,m2,m1,m0. For each column j, the permuted byte in row k is the XOR over i=0..3 of (byte of row i, column j) AND M[(k+i) mod 4].
- R2: With `odd_round`=0, the mask sequence is M[0..3] = m1,m0,m3,m2. This is the odd sequence rotated by two places, and it is used in the same formula.
- R3: After the permutation, the byte at row i, column j of the intermediate moves to row j, column i.
- R4: Output word i equals transposed word i XOR key word i (bits 32i+31..32i). An all-zero state therefore outputs the key unchanged.
- R5: With an all-zero key, the output is the permutation followed by the transposition only. It is linear: f(x XOR y) = f(x) XOR f(y).
- R6: With `REG_OUT`=1, `out_valid` is `in_valid` delayed by one clock. `out_data` then holds the result for the inputs of the previous cycle.
- R7: A synchronous `rst` clears both `out_valid` and `out_data` to zero at the next clock.
- R8: While `in_valid` is low, `out_data` keeps its last value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe |
| odd_round | input | 1 | 1 selects the odd-round mask sequence, 0 the even one |
| in_state | input | 128 | State word i at bits 32i+31..32i |
| in_key | input | 128 | Round key, same layout |
| out_valid | output | 1 | Result strobe |
| out_data | output | 128 | Permuted, transposed and key-mixed state |

## Verification
The assertions assume that reset is asserted before the first strobe. They also assume that all inputs are known at every rising edge. Because the output register loads only on a strobe, the hold and idle properties additionally require that `in_valid` is never left undefined. The stimulus meets these conditions by holding reset for several cycles at start-up and by driving every input from a single task on the falling edge. It also randomises the state, key and round select only while the strobe is driven to a defined level.

// File: rtl/spn_lin_layer.sv
module spn_lin_layer #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         odd_round,
  input  logic [127:0] in_state,
  input  logic [127:0] in_key,
  output logic         out_valid,
  output logic [127:0] out_data
);
  localparam int NB = 8;
  localparam int NL = 4;
  localparam int WW = NB * NL;
  localparam logic [NB-1:0] MASK [NL] = '{8'hfc, 8'hf3, 8'hcf, 8'h3f};

  logic [NB-1:0]   msk [NL];
  logic [4*WW-1:0] pm, tr, res;

  always_comb begin
    for (int n = 0; n < NL; n++)
      msk[n] = MASK[(NL - 1 - n + (odd_round ? 0 : 2)) % NL];
  end

  always_comb begin
    for (int j = 0; j < NL; j++) begin
      for (int k = 0; k < NL; k++) begin
        logic [NB-1:0] acc;
        acc = '0;
        for (int i = 0; i < NL; i++)
          acc ^= in_state[WW*i + NB*j +: NB] & msk[(k + i) % NL];
        pm[WW*k + NB*j +: NB] = acc;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NL; i++)
      for (int j = 0; j < NL; j++)
        tr[WW*i + NB*j +: NB] = pm[WW*j + NB*i +: NB];
  end

  assign res = tr ^ in_key;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          out_data  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_data <= res;
        end
      end

      a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
      a_r4_key_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_state == '0) |=> out_data == $past(in_key));
      a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_data  = res;
    end
  endgenerate
endmodule

// File: tb/sim_spn_lin_layer.sv
module sim_spn_lin_layer;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         odd_round = 1'b0;
  logic [127:0] in_state = '0;
  logic [127:0] in_key = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [127:0] exp_q [$];
  string        tag_q [$];
  logic [127:0] got_q [$];
  logic [127:0] last_exp;

  spn_lin_layer #(.REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .odd_round(odd_round),
    .in_state(in_state), .in_key(in_key),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mseq(input bit odd, input int n);
    logic [7:0] odd_s [4];
    logic [7:0] even_s [4];
    odd_s  = '{8'h3f, 8'hcf, 8'hf3, 8'hfc};
    even_s = '{8'hf3, 8'hfc, 8'h3f, 8'hcf};
    return odd ? odd_s[n] : even_s[n];
  endfunction

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] k, input bit odd);
    logic [127:0] o;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        for (int b = 0; b < 8; b++) begin
          logic x;
          x = k[32*r + 8*c + b];
          for (int i = 0; i < 4; i++)
            x ^= s[32*i + 8*r + b] & mseq(odd, (c + i) % 4)[b];
          o[32*r + 8*c + b] = x;
        end
    return o;
  endfunction

  function automatic logic [127:0] xpose(input logic [127:0] s);
    logic [127:0] o;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        o[32*i + 8*j +: 8] = s[32*j + 8*i +: 8];
    return o;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] s, input logic [127:0] k, input bit odd,
                      input string req, input logic [127:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_state = s; in_key = k; odd_round = odd;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    last_exp = exp;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_state = {$urandom, $urandom, $urandom, $urandom};
      in_key   = {$urandom, $urandom, $urandom, $urandom};
      odd_round = $urandom % 2;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: actual valid 1 expected 0");
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          got_q.push_back(out_data);
          check(t, out_data, e);
        end
      end else if (exp_q.size() != 0) begin
        checks++; errors++;
        $display("FAIL R6: actual valid 0 expected 1");
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] x, y, k;
    repeat (3) @(negedge clk);
    check("R7 reset valid", {127'd0, out_valid}, 128'd0);
    check("R7 reset data", out_data, 128'd0);
    @(negedge clk); rst = 1'b0;

    send(128'h00000000_00000000_00ff0000_00000000, '0, 1'b1, "R1 directed odd",
         128'h00000000_3ffcf3cf_00000000_00000000);
    send(128'h00000000_00000000_00ff0000_00000000, '0, 1'b0, "R2 directed even",
         128'h00000000_f3cf3ffc_00000000_00000000);
    k = 128'h0123456789abcdef_fedcba9876543210;
    send('0, k, 1'b1, "R4 zero state odd", k);
    send('0, ~k, 1'b0, "R4 zero state even", ~k);
    for (int n = 0; n < 40; n++) begin
      x = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      send(x, k, n[0], n[0] ? "R1 R3 R4 random odd" : "R2 R3 R4 random even", model(x, k, n[0]));
    end

    for (int n = 0; n < 4; n++) begin
      x = {$urandom, $urandom, $urandom, $urandom};
      check("R3 transpose twice", xpose(xpose(x)), x);
    end

    idle(1);
    repeat (3) begin
      @(posedge clk); #2;
      check("R8 hold when idle", out_data, last_exp);
    end

    for (int m = 0; m < 2; m++) begin
      got_q.delete();
      x = {$urandom, $urandom, $urandom, $urandom};
      y = {$urandom, $urandom, $urandom, $urandom};
      send(x, '0, m[0], "R5 zero key x", model(x, '0, m[0]));
      send(y, '0, m[0], "R5 zero key y", model(y, '0, m[0]));
      send(x ^ y, '0, m[0], "R5 zero key x^y", model(x ^ y, '0, m[0]));
      idle(2);
      if (got_q.size() == 3)
        check("R5 linearity", got_q[0] ^ got_q[1], got_q[2]);
      else
        check("R5 output count", 128'(got_q.size()), 128'd3);
    end

    send(128'h1, 128'h2, 1'b1, "R6 before reset", model(128'h1, 128'h2, 1'b1));
    idle(1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check("R7 mid-run reset valid", {127'd0, out_valid}, 128'd0);
    check("R7 mid-run reset data", out_data, 128'd0);
    @(negedge clk); rst = 1'b0;
    idle(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule